// File: doc/BRIEF.md
# Watchdog with Safe-Frequency Recovery

This block guards a clock synthesizer against a frequency setting that hangs the system. Software picks a timeout in coarse units, writes the enable bit, and from then on the counter drops by one on every prescaler tick. A tick nominally lasts 250 ms. If software never disarms or re-arms it, the count runs out and the block takes three actions at once. It raises a sticky timeout flag. It pulls an open-drain system reset low for one tick period. It also replaces the active frequency code with a known-good one and leaves direct M/N programming mode.

Software chooses the recovery code with a reload-select bit. When the bit is clear, the block restores the code latched from the strap pins at reset. When it is set, the block uses a safe code that software wrote beforehand. The synthesizer itself is outside this block: it reads `active_code` and `mn_en`. The tick length is the parameter `TICK_CYCLES`, which a test can shrink to a few cycles.

Top module: `wdog_freq_guard`

## Requirements
- R1: After reset: `wd_count` = 8, `wd_running` = 0, `wd_timeout` = 0, `rst_drive_n` = 1, `mn_en` = 0, `reload_sel` = 0, `safe_code` = 0, and `active_code` equals `strap_code`.
- R2: A write on `code_wr` or `mn_wr` shows on `active_code` or `mn_en` one cycle later.
- R3: A write on `time_wr`, `safe_wr` or `rsel_wr` is stored one cycle later and appears on the matching output. A time value written while the timer is stopped also appears on `wd_count`. While the timer runs, a time write does not change `wd_count`; it is used by the next arm.
- R4: A write of 1 on the enable bit (`en_wr`, `en_wdata` = 1) arms the timer. One cycle later `wd_running` = 1, `wd_timeout` = 0, and `wd_count` holds the stored time value. The prescaler restarts from zero.
- R5: While the timer runs, `wd_count` drops by exactly one every `TICK_CYCLES` cycles. The first drop comes `TICK_CYCLES` cycles after the arm edge.
- R6: The tick that would take the count from 1 to 0 is a timeout. In that cycle `wd_timeout` becomes 1, `wd_running` becomes 0 and `wd_count` becomes 0, and the count then holds until the next arm.
- R7: `rst_drive_n` (0 = pull reset low) goes to 0 in the timeout cycle and stays at 0 for exactly `TICK_CYCLES` cycles.
- R8: In the timeout cycle, `active_code` becomes `strap_code` if `reload_sel` = 0, and becomes `safe_code` if `reload_sel` = 1.
- R9: A timeout clears `mn_en`. In the timeout cycle, a timeout overrides any software write to the code or to `mn_en`.
- R10: A write of 0 on the enable bit stops the timer one cycle later. `wd_count` then freezes, and no timeout and no reset pulse follow.
- R11: Arming with a time value of 0 causes a timeout on the first tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_code | input | CODE_W | Frequency code latched from the strap pins |
| code_wr | input | 1 | Write strobe for the software frequency code |
| code_wdata | input | CODE_W | Software frequency code |
| mn_wr | input | 1 | Write strobe for the M/N mode enable |
| mn_wdata | input | 1 | M/N mode enable value |
| rsel_wr | input | 1 | Write strobe for reload select |
| rsel_wdata | input | 1 | Reload select (0 = strap, 1 = safe code) |
| safe_wr | input | 1 | Write strobe for the safe code |
| safe_wdata | input | CODE_W | Safe code value |
| time_wr | input | 1 | Write strobe for the timeout value |
| time_wdata | input | TIME_W | Timeout in ticks |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_wdata | input | 1 | 1 arms the timer, 0 stops it |
| active_code | output | CODE_W | Frequency code currently in force |
| mn_en | output | 1 | Direct M/N programming mode |
| reload_sel | output | 1 | Stored reload select |
| safe_code | output | CODE_W | Stored safe code |
| wd_count | output | TIME_W | Current count |
| wd_running | output | 1 | 1 while the timer counts |
| wd_timeout | output | 1 | Sticky timeout status |
| rst_drive_n | output | 1 | Reset pull-down enable, 0 = drive low |

## Verification
Every register write shows on the outputs one edge after the cycle that drives the strobe. A timer armed at edge A holds the count N until edge A+T-1. It then steps down at edges A+T, A+2T and so on, and the timeout effects appear together at edge A+N·T. The reset output releases at edge A+(N+1)·T. The driver task records every expectation under the edge count at which it is due. The monitor compares the outputs at the falling edge that follows that rising edge. Edges just before a step are checked as well as edges just after, so an off-by-one in the prescaler or in the pulse length shows up as a mismatch.

// File: rtl/wdog_freq_guard.sv
module wdog_freq_guard #(
  parameter int TICK_CYCLES = 3579545,
  parameter int TIME_W      = 8,
  parameter int CODE_W      = 5,
  parameter int TIME_RST    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] strap_code,
  input  logic              code_wr,
  input  logic [CODE_W-1:0] code_wdata,
  input  logic              mn_wr,
  input  logic              mn_wdata,
  input  logic              rsel_wr,
  input  logic              rsel_wdata,
  input  logic              safe_wr,
  input  logic [CODE_W-1:0] safe_wdata,
  input  logic              time_wr,
  input  logic [TIME_W-1:0] time_wdata,
  input  logic              en_wr,
  input  logic              en_wdata,
  output logic [CODE_W-1:0] active_code,
  output logic              mn_en,
  output logic              reload_sel,
  output logic [CODE_W-1:0] safe_code,
  output logic [TIME_W-1:0] wd_count,
  output logic              wd_running,
  output logic              wd_timeout,
  output logic              rst_drive_n
);
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0]     presc, rcnt;
  logic [TIME_W-1:0] time_cfg;
  logic              rst_lo;

  wire arm    = en_wr & en_wdata;
  wire tick   = wd_running & (presc == LAST);
  wire expire = tick & (wd_count <= TIME_W'(1)) & ~en_wr;

  assign rst_drive_n = ~rst_lo;

  // R1 reset state, R3 register writes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_cfg   <= TIME_W'(TIME_RST);
      safe_code  <= '0;
      reload_sel <= 1'b0;
    end else begin
      if (time_wr) time_cfg   <= time_wdata;
      if (safe_wr) safe_code  <= safe_wdata;
      if (rsel_wr) reload_sel <= rsel_wdata;
    end
  end

  // R4 arm, R5 cadence, R6 timeout, R10 stop, R11 zero arm
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wd_count   <= TIME_W'(TIME_RST);
      wd_running <= 1'b0;
      wd_timeout <= 1'b0;
      presc      <= '0;
    end else begin
      if (arm)
        wd_count <= time_wr ? time_wdata : time_cfg;
      else if (tick && !en_wr)
        wd_count <= expire ? '0 : wd_count - 1'b1;
      else if (time_wr && !wd_running)
        wd_count <= time_wdata;

      if (arm)         wd_running <= 1'b1;
      else if (en_wr)  wd_running <= 1'b0;
      else if (expire) wd_running <= 1'b0;

      if (arm)         wd_timeout <= 1'b0;
      else if (expire) wd_timeout <= 1'b1;

      if (arm || !wd_running || tick) presc <= '0;
      else                            presc <= presc + 1'b1;
    end
  end

  // R8 code restore, R9 M/N clear with priority over software
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_code <= strap_code;
      mn_en       <= 1'b0;
    end else if (expire) begin
      active_code <= reload_sel ? safe_code : strap_code;
      mn_en       <= 1'b0;
    end else begin
      if (code_wr) active_code <= code_wdata;
      if (mn_wr)   mn_en       <= mn_wdata;
    end
  end

  // R7 reset pulse of one tick period
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_lo <= 1'b0;
      rcnt   <= '0;
    end else if (expire) begin
      rst_lo <= 1'b1;
      rcnt   <= '0;
    end else if (rst_lo) begin
      if (rcnt == LAST) begin
        rst_lo <= 1'b0;
        rcnt   <= '0;
      end else begin
        rcnt <= rcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdog_freq_guard_chk.sv
module wdog_freq_guard_chk #(
  parameter int TICK_CYCLES = 3579545,
  parameter int TIME_W      = 8,
  parameter int CODE_W      = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_wr,
  input logic [CODE_W-1:0] strap_code,
  input logic              reload_sel,
  input logic [CODE_W-1:0] safe_code,
  input logic [CODE_W-1:0] active_code,
  input logic              mn_en,
  input logic [TIME_W-1:0] wd_count,
  input logic              wd_running,
  input logic              wd_timeout,
  input logic              rst_drive_n
);
  int lowrun;
  always_ff @(posedge clk) begin
    if (!rst_n)            lowrun <= 0;
    else if (!rst_drive_n) lowrun <= lowrun + 1;
    else                   lowrun <= 0;
  end

  a_r7_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_drive_n) |-> lowrun == TICK_CYCLES);

  a_r7_pulse_cap: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_drive_n |-> lowrun < TICK_CYCLES);

  a_r6_timeout_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_timeout) |-> (!wd_running && wd_count == '0));

  a_r7_pulse_with_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_drive_n) |-> (wd_timeout && !wd_running));

  a_r8_code_restore: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_timeout) |->
      active_code == ($past(reload_sel) ? $past(safe_code) : $past(strap_code)));

  a_r9_mn_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_timeout) |-> !mn_en);

  a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_running && $past(wd_running) && !$past(en_wr)) |->
      (wd_count == $past(wd_count) || wd_count == $past(wd_count) - 1'b1));
endmodule

bind wdog_freq_guard wdog_freq_guard_chk #(
  .TICK_CYCLES(TICK_CYCLES), .TIME_W(TIME_W), .CODE_W(CODE_W)
) u_chk (.*);

// File: tb/tb_wdog_freq_guard.sv
module tb_wdog_freq_guard;
  localparam int CLK_PERIOD = 10;
  localparam int T = 4;
  localparam logic [4:0] STRAP = 5'h13;

  logic clk = 0, rst_n = 0;
  logic code_wr = 0, mn_wr = 0, mn_wdata = 0, rsel_wr = 0, rsel_wdata = 0;
  logic safe_wr = 0, time_wr = 0, en_wr = 0, en_wdata = 0;
  logic [4:0] code_wdata = 0, safe_wdata = 0;
  logic [7:0] time_wdata = 0;
  logic [4:0] active_code, safe_code;
  logic [7:0] wd_count;
  logic mn_en, reload_sel, wd_running, wd_timeout, rst_drive_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_freq_guard #(.TICK_CYCLES(T)) dut (
    .clk(clk), .rst_n(rst_n), .strap_code(STRAP),
    .code_wr(code_wr), .code_wdata(code_wdata), .mn_wr(mn_wr), .mn_wdata(mn_wdata),
    .rsel_wr(rsel_wr), .rsel_wdata(rsel_wdata), .safe_wr(safe_wr), .safe_wdata(safe_wdata),
    .time_wr(time_wr), .time_wdata(time_wdata), .en_wr(en_wr), .en_wdata(en_wdata),
    .active_code(active_code), .mn_en(mn_en), .reload_sel(reload_sel), .safe_code(safe_code),
    .wd_count(wd_count), .wd_running(wd_running), .wd_timeout(wd_timeout),
    .rst_drive_n(rst_drive_n));

  wire [22:0] obs = {rst_drive_n, wd_timeout, wd_running, mn_en, reload_sel,
                     safe_code, active_code, wd_count};

  typedef struct { int cyc; logic [22:0] exp; string req; } item_t;
  item_t q[$];
  int ec = 0, checks = 0, fails = 0;
  bit done = 0;

  logic m_rst, m_to, m_run, m_mn, m_rsel;
  logic [4:0] m_safe, m_code;
  logic [7:0] m_cnt;

  always @(posedge clk) ec <= ec + 1;

  task automatic expect_at(int c, string req);
    item_t it;
    bit put = 0;
    it.cyc = c; it.req = req;
    it.exp = {m_rst, m_to, m_run, m_mn, m_rsel, m_safe, m_code, m_cnt};
    for (int i = 0; i < q.size(); i++)
      if (!put && q[i].cyc > c) begin q.insert(i, it); put = 1; end
    if (!put) q.push_back(it);
  endtask

  task automatic wait_until(int c);
    while (ec < c) @(negedge clk);
  endtask

  task automatic release_writes();
    @(negedge clk);
    code_wr = 0; mn_wr = 0; rsel_wr = 0; safe_wr = 0; time_wr = 0; en_wr = 0;
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= ec) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (it.cyc < ec) begin
        fails++;
        $display("FAIL %s missed at cycle %0d actual=%h expected=%h", it.req, it.cyc, obs, it.exp);
      end else if (obs !== it.exp) begin
        fails++;
        $display("FAIL %s cycle %0d actual=%h expected=%h", it.req, ec, obs, it.exp);
      end
    end
  end

  initial begin
    int a;
    m_rst = 1; m_to = 0; m_run = 0; m_mn = 0; m_rsel = 0;
    m_safe = 0; m_code = STRAP; m_cnt = 8;
    repeat (3) @(negedge clk);
    rst_n = 1;
    expect_at(ec + 1, "R1");

    @(negedge clk);
    code_wr = 1; code_wdata = 5'h0A; mn_wr = 1; mn_wdata = 1;
    m_code = 5'h0A; m_mn = 1; expect_at(ec + 1, "R2");
    release_writes();

    safe_wr = 1; safe_wdata = 5'h15; rsel_wr = 1; rsel_wdata = 1;
    time_wr = 1; time_wdata = 8'd3;
    m_safe = 5'h15; m_rsel = 1; m_cnt = 3; expect_at(ec + 1, "R3");
    release_writes();

    en_wr = 1; en_wdata = 1; a = ec + 1;
    m_run = 1; expect_at(a, "R4");
    expect_at(a + T - 1, "R5");
    m_cnt = 2; expect_at(a + T, "R5");
    m_cnt = 1; expect_at(a + 2*T, "R5"); expect_at(a + 3*T - 1, "R5");
    m_cnt = 0; m_run = 0; m_to = 1; m_rst = 0; m_mn = 0; m_code = 5'h15;
    expect_at(a + 3*T, "R6"); expect_at(a + 3*T, "R8");
    expect_at(a + 4*T - 1, "R7");
    m_rst = 1; expect_at(a + 4*T, "R7");
    release_writes();
    time_wr = 1; time_wdata = 8'd6;
    release_writes();
    wait_until(a + 4*T + 1);

    rsel_wr = 1; rsel_wdata = 0; mn_wr = 1; mn_wdata = 1;
    m_rsel = 0; m_mn = 1; expect_at(ec + 1, "R3");
    release_writes();
    en_wr = 1; en_wdata = 1; a = ec + 1;
    m_run = 1; m_to = 0; m_cnt = 6; expect_at(a, "R3"); expect_at(a, "R4");
    m_cnt = 0; m_run = 0; m_to = 1; m_rst = 0; m_mn = 0; m_code = STRAP;
    expect_at(a + 6*T, "R9"); expect_at(a + 6*T, "R8");
    m_rst = 1; expect_at(a + 7*T, "R7");
    release_writes();
    wait_until(a + 6*T - 1);
    code_wr = 1; code_wdata = 5'h1C; mn_wr = 1; mn_wdata = 1;
    release_writes();
    wait_until(a + 7*T + 1);

    time_wr = 1; time_wdata = 8'd5;
    m_cnt = 5; expect_at(ec + 1, "R3");
    release_writes();
    en_wr = 1; en_wdata = 1; a = ec + 1;
    m_run = 1; m_to = 0; expect_at(a, "R4");
    release_writes();
    wait_until(a + 2*T + 1);
    en_wr = 1; en_wdata = 0;
    m_run = 0; m_cnt = 3; expect_at(a + 2*T + 2, "R10");
    expect_at(a + 10*T, "R10");
    release_writes();
    wait_until(a + 10*T + 1);

    time_wr = 1; time_wdata = 8'd0; rsel_wr = 1; rsel_wdata = 1;
    m_cnt = 0; m_rsel = 1; expect_at(ec + 1, "R3");
    release_writes();
    en_wr = 1; en_wdata = 1; a = ec + 1;
    m_run = 1; expect_at(a, "R11"); expect_at(a + T - 1, "R11");
    m_run = 0; m_to = 1; m_rst = 0; m_code = 5'h15; expect_at(a + T, "R11");
    m_rst = 1; expect_at(a + 2*T, "R7");
    release_writes();

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule